// File: doc/BRIEF.md
# Prioritized Interrupt Arbiter with Mask Write-Back

This block collects interrupt requests from a small set of external pins, a bank of on-chip peripheral sources and one non-maskable input. Each maskable source carries a software-programmed priority. Each cycle the block picks the single most urgent request and checks it against the processor's current mask, a separate user-mode mask and the processor's block bit. It offers the result to the processor through a valid/level/identifier handshake. When the processor acknowledges, the block pulses a mask write-back carrying the accepted level and clears the request that was serviced.

External pins can either be followed live or captured, as software selects. In capture mode a short pulse on a pin leaves a sticky request. That request remains until software clears it by writing a one to its status bit, or until the processor acknowledges that source. The non-maskable input is captured on its rising edge. Its raw pin level is readable by software, so a handler can recheck the pin. A control bit chooses whether the non-maskable request may pass while the processor's block bit is set.

The processor-side sequencer has three states. IDLE moves to OFFER when a qualified winner exists. OFFER moves to ACCEPT on an acknowledge, moves back to IDLE when no qualified winner remains, and otherwise stays in OFFER and re-samples the winner. ACCEPT always returns to IDLE.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Register word 4 holds one 4-bit priority per external pin, with pin i at bits [4i+3:4i]. Writes are read back unchanged, and a pin whose priority is 0 never produces a request.
- R2: Register words 8 and up hold one 5-bit priority per peripheral source, with source k in word 8+k/4 at bits [8(k%4)+4:8(k%4)]. A written value of 31 is stored and read back as 30. A priority of 0 disables the source.
- R3: Source identifiers are 0 for the non-maskable input, 1..N_EXT for the pins and N_EXT+1.. for the peripherals. The pending source with the highest priority wins, and on equal priority the lower identifier wins.
- R4: A maskable winner is offered only when its level is strictly above the processor mask input, strictly above the user mask (word 1, bits [4:0]), and the block bit input is 0.
- R5: The non-maskable request is captured on a rising edge of its pin. It is offered with identifier 0 and level 31 regardless of both masks. While the block bit is 1 it is held back unless control bit 0 (word 0) is 1, and it stays pending until it is acknowledged.
- R6: Control word bit 8 reads the present level of the non-maskable pin.
- R7: Control bit 1 (word 0) selects capture mode for the pins and resets to 0, which means the pins are followed live. In capture mode a pin pulse sets a sticky bit, readable in word 2 bit i, that keeps the request alive after the pin falls.
- R8: Writing a one to a bit of word 2 clears that captured bit. An acknowledge of a pin's request also clears that pin's captured bit.
- R9: One cycle after a qualified winner appears in IDLE, req_valid rises with the winner's level and identifier. An acknowledge while req_valid is high leads to one cycle of imask_wr carrying the accepted level, with req_valid low, followed by IDLE.
- R10: After reset all outputs are low and all registers read 0, except the pin-level bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| ext_irq | input | N_EXT | Level-sensed external interrupt pins |
| per_irq | input | N_PER | Peripheral interrupt requests |
| nmi_pin | input | 1 | Non-maskable interrupt pin |
| cpu_bl | input | 1 | Processor block bit |
| cpu_imask | input | 5 | Processor current interrupt mask level |
| cpu_ack | input | 1 | Processor acknowledge of the offered request |
| req_valid | output | 1 | A request is offered (state OFFER) |
| req_level | output | 5 | Level of the offered request |
| req_id | output | ID_W | Identifier of the offered request |
| imask_wr | output | 1 | One-cycle mask write-back pulse (state ACCEPT) |
| imask_level | output | 5 | Level to write into the processor mask |

## Verification
The bench uses the default build: four external pins and eight peripheral sources, which gives a 4-bit identifier. With these values one peripheral word holds a clamped field and a disabled field side by side. They also allow an external pin and a peripheral to be given the same level, so the identifier tie-break can be exercised. The behavioural model is compared with every register read and handshake output on every clock, so winner changes in the middle of an offer and mask changes at state boundaries are covered as well as the settled cases.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int LVL_W     = 5;
    localparam int EXT_LVL_W = 4;
    localparam int AW        = 4;
    localparam int DW        = 32;
    localparam int PER_LANE  = 8;
    localparam int PER_PER_WORD = DW / PER_LANE;

    localparam logic [LVL_W-1:0] NMI_LVL     = 5'd31;
    localparam logic [LVL_W-1:0] PER_LVL_MAX = 5'd30;

    localparam int ADR_CTRL   = 0;
    localparam int ADR_UMASK  = 1;
    localparam int ADR_HOLD   = 2;
    localparam int ADR_EXTPRI = 4;
    localparam int ADR_PERPRI = 8;

    localparam int CTRL_PASS_BIT = 0;
    localparam int CTRL_HOLD_BIT = 1;
    localparam int CTRL_PIN_BIT  = 8;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_OFFER  = 2'd1,
        ST_ACCEPT = 2'd2
    } cpu_st_e;
endpackage

// File: rtl/pic_regs.sv
module pic_regs
    import pic_pkg::*;
#(
    parameter int N_EXT = 4,
    parameter int N_PER = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_we,
    input  logic [AW-1:0]              reg_addr,
    input  logic [DW-1:0]              reg_wdata,
    output logic [DW-1:0]              reg_rdata,
    input  logic                       nmi_pin,
    input  logic [N_EXT-1:0]           hold_q,
    output logic                       nmi_pass_bl,
    output logic                       hold_en,
    output logic [LVL_W-1:0]           umask,
    output logic [N_EXT*EXT_LVL_W-1:0] ext_pri,
    output logic [N_PER*LVL_W-1:0]     per_pri,
    output logic [N_EXT-1:0]           hold_w1c
);
    localparam int EXT_BITS = N_EXT * EXT_LVL_W;

    function automatic logic [LVL_W-1:0] sat_lvl(input logic [LVL_W-1:0] v);
        return (v > PER_LVL_MAX) ? PER_LVL_MAX : v;
    endfunction

    function automatic logic [AW-1:0] per_word(input int idx);
        return AW'(ADR_PERPRI + idx / PER_PER_WORD);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_pass_bl <= 1'b0;
            hold_en     <= 1'b0;
            umask       <= '0;
            ext_pri     <= '0;
            per_pri     <= '0;
        end else if (reg_we) begin
            if (reg_addr == AW'(ADR_CTRL)) begin
                nmi_pass_bl <= reg_wdata[CTRL_PASS_BIT];
                hold_en     <= reg_wdata[CTRL_HOLD_BIT];
            end
            if (reg_addr == AW'(ADR_UMASK))
                umask <= reg_wdata[LVL_W-1:0];
            if (reg_addr == AW'(ADR_EXTPRI))
                ext_pri <= reg_wdata[EXT_BITS-1:0];
            for (int i = 0; i < N_PER; i++) begin
                if (reg_addr == per_word(i))
                    per_pri[i*LVL_W +: LVL_W] <=
                        sat_lvl(reg_wdata[(i % PER_PER_WORD)*PER_LANE +: LVL_W]);
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == AW'(ADR_CTRL)) begin
            reg_rdata[CTRL_PASS_BIT] = nmi_pass_bl;
            reg_rdata[CTRL_HOLD_BIT] = hold_en;
            reg_rdata[CTRL_PIN_BIT]  = nmi_pin;
        end
        if (reg_addr == AW'(ADR_UMASK))
            reg_rdata[LVL_W-1:0] = umask;
        if (reg_addr == AW'(ADR_HOLD))
            reg_rdata[N_EXT-1:0] = hold_q;
        if (reg_addr == AW'(ADR_EXTPRI))
            reg_rdata[EXT_BITS-1:0] = ext_pri;
        for (int i = 0; i < N_PER; i++) begin
            if (reg_addr == per_word(i))
                reg_rdata[(i % PER_PER_WORD)*PER_LANE +: LVL_W] = per_pri[i*LVL_W +: LVL_W];
        end
    end

    assign hold_w1c = (reg_we && reg_addr == AW'(ADR_HOLD)) ? reg_wdata[N_EXT-1:0] : '0;

    generate
        for (genvar g = 0; g < N_PER; g++) begin : g_sat
            // R2
            per_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (reg_we && reg_addr == per_word(g)
                 && reg_wdata[(g % PER_PER_WORD)*PER_LANE +: LVL_W] == 5'd31)
                |=> per_pri[g*LVL_W +: LVL_W] == PER_LVL_MAX);
        end
    endgenerate
endmodule

// File: rtl/pic_capture.sv
module pic_capture
    import pic_pkg::*;
#(
    parameter int N_EXT = 4,
    parameter int ID_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_en,
    input  logic [N_EXT-1:0] ext_irq,
    input  logic             nmi_pin,
    input  logic [N_EXT-1:0] hold_w1c,
    input  logic             clr_valid,
    input  logic [ID_W-1:0]  clr_id,
    output logic [N_EXT-1:0] ext_pend,
    output logic [N_EXT-1:0] hold_q,
    output logic             nmi_pend
);
    logic [N_EXT-1:0] ack_clr;
    logic             nmi_prev;

    generate
        for (genvar g = 0; g < N_EXT; g++) begin : g_clr
            assign ack_clr[g] = clr_valid && (clr_id == ID_W'(g + 1));
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q   <= '0;
            nmi_prev <= 1'b0;
            nmi_pend <= 1'b0;
        end else begin
            hold_q   <= hold_en ? (ext_irq | (hold_q & ~(hold_w1c | ack_clr))) : '0;
            nmi_prev <= nmi_pin;
            nmi_pend <= (nmi_pend && !(clr_valid && clr_id == '0))
                        || (nmi_pin && !nmi_prev);
        end
    end

    assign ext_pend = hold_en ? (ext_irq | hold_q) : ext_irq;

    // R7
    live_mode_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_en |=> hold_q == '0);

    // R5
    nmi_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_pin) |=> nmi_pend);
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
    import pic_pkg::*;
#(
    parameter int N_EXT = 4,
    parameter int N_PER = 8,
    parameter int ID_W  = 4
) (
    input  logic [N_EXT-1:0]           ext_pend,
    input  logic [N_PER-1:0]           per_pend,
    input  logic [N_EXT*EXT_LVL_W-1:0] ext_pri,
    input  logic [N_PER*LVL_W-1:0]     per_pri,
    input  logic                       nmi_pend,
    input  logic                       nmi_ok,
    input  logic                       cpu_bl,
    input  logic [LVL_W-1:0]           cpu_imask,
    input  logic [LVL_W-1:0]           umask,
    output logic                       win_valid,
    output logic [LVL_W-1:0]           win_lvl,
    output logic [ID_W-1:0]            win_id
);
    logic [LVL_W-1:0] best_lvl;
    logic [ID_W-1:0]  best_id;
    logic             mask_ok;

    always_comb begin
        best_lvl = '0;
        best_id  = '0;
        for (int i = 0; i < N_EXT; i++) begin
            if (ext_pend[i] && LVL_W'(ext_pri[i*EXT_LVL_W +: EXT_LVL_W]) > best_lvl) begin
                best_lvl = LVL_W'(ext_pri[i*EXT_LVL_W +: EXT_LVL_W]);
                best_id  = ID_W'(1 + i);
            end
        end
        for (int j = 0; j < N_PER; j++) begin
            if (per_pend[j] && per_pri[j*LVL_W +: LVL_W] > best_lvl) begin
                best_lvl = per_pri[j*LVL_W +: LVL_W];
                best_id  = ID_W'(1 + N_EXT + j);
            end
        end
    end

    assign mask_ok = !cpu_bl && (best_lvl > cpu_imask) && (best_lvl > umask);

    always_comb begin
        win_valid = 1'b0;
        win_lvl   = '0;
        win_id    = '0;
        if (nmi_pend && nmi_ok) begin
            win_valid = 1'b1;
            win_lvl   = NMI_LVL;
            win_id    = '0;
        end else if (mask_ok) begin
            win_valid = 1'b1;
            win_lvl   = best_lvl;
            win_id    = best_id;
        end
    end
endmodule

// File: rtl/pic_cpu_fsm.sv
module pic_cpu_fsm
    import pic_pkg::*;
#(
    parameter int ID_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_valid,
    input  logic [LVL_W-1:0] win_lvl,
    input  logic [ID_W-1:0]  win_id,
    input  logic             cpu_ack,
    output logic             req_valid,
    output logic [LVL_W-1:0] req_level,
    output logic [ID_W-1:0]  req_id,
    output logic             imask_wr,
    output logic [LVL_W-1:0] imask_level,
    output logic             ack_take,
    output logic [ID_W-1:0]  ack_id
);
    cpu_st_e          st_q, st_d;
    logic [LVL_W-1:0] lvl_q;
    logic [ID_W-1:0]  id_q;
    logic             load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        load = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (win_valid) begin
                    st_d = ST_OFFER;
                    load = 1'b1;
                end
            end
            ST_OFFER: begin
                if (cpu_ack) begin
                    st_d = ST_ACCEPT;
                end else if (win_valid) begin
                    st_d = ST_OFFER;
                    load = 1'b1;
                end else begin
                    st_d = ST_IDLE;
                end
            end
            ST_ACCEPT: st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= '0;
            id_q  <= '0;
        end else if (load) begin
            lvl_q <= win_lvl;
            id_q  <= win_id;
        end
    end

    always_comb begin
        req_valid   = (st_q == ST_OFFER);
        imask_wr    = (st_q == ST_ACCEPT);
        req_level   = lvl_q;
        req_id      = id_q;
        imask_level = lvl_q;
        ack_take    = (st_q == ST_OFFER) && cpu_ack;
        ack_id      = id_q;
    end

    // R9
    ack_to_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cpu_ack) |=> imask_wr);

    // R9
    accept_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        imask_wr |=> !imask_wr && !req_valid);

    // R9
    accept_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cpu_ack) |=> imask_level == $past(req_level));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter int N_EXT = 4,
    parameter int N_PER = 8,
    localparam int ID_W = $clog2(1 + N_EXT + N_PER)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [3:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic [N_EXT-1:0] ext_irq,
    input  logic [N_PER-1:0] per_irq,
    input  logic             nmi_pin,
    input  logic             cpu_bl,
    input  logic [4:0]       cpu_imask,
    input  logic             cpu_ack,
    output logic             req_valid,
    output logic [4:0]       req_level,
    output logic [ID_W-1:0]  req_id,
    output logic             imask_wr,
    output logic [4:0]       imask_level
);
    logic                       nmi_pass_bl;
    logic                       hold_en;
    logic [LVL_W-1:0]           umask;
    logic [N_EXT*EXT_LVL_W-1:0] ext_pri;
    logic [N_PER*LVL_W-1:0]     per_pri;
    logic [N_EXT-1:0]           hold_w1c;
    logic [N_EXT-1:0]           hold_q;
    logic [N_EXT-1:0]           ext_pend;
    logic                       nmi_pend;
    logic                       win_valid;
    logic [LVL_W-1:0]           win_lvl;
    logic [ID_W-1:0]            win_id;
    logic                       ack_take;
    logic [ID_W-1:0]            ack_id;

    pic_regs #(.N_EXT(N_EXT), .N_PER(N_PER)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .nmi_pin(nmi_pin), .hold_q(hold_q),
        .nmi_pass_bl(nmi_pass_bl), .hold_en(hold_en), .umask(umask),
        .ext_pri(ext_pri), .per_pri(per_pri), .hold_w1c(hold_w1c)
    );

    pic_capture #(.N_EXT(N_EXT), .ID_W(ID_W)) u_capture (
        .clk(clk), .rst_n(rst_n),
        .hold_en(hold_en), .ext_irq(ext_irq), .nmi_pin(nmi_pin),
        .hold_w1c(hold_w1c), .clr_valid(ack_take), .clr_id(ack_id),
        .ext_pend(ext_pend), .hold_q(hold_q), .nmi_pend(nmi_pend)
    );

    pic_arbiter #(.N_EXT(N_EXT), .N_PER(N_PER), .ID_W(ID_W)) u_arbiter (
        .ext_pend(ext_pend), .per_pend(per_irq),
        .ext_pri(ext_pri), .per_pri(per_pri),
        .nmi_pend(nmi_pend), .nmi_ok(!cpu_bl || nmi_pass_bl),
        .cpu_bl(cpu_bl), .cpu_imask(cpu_imask), .umask(umask),
        .win_valid(win_valid), .win_lvl(win_lvl), .win_id(win_id)
    );

    pic_cpu_fsm #(.ID_W(ID_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .win_valid(win_valid), .win_lvl(win_lvl), .win_id(win_id),
        .cpu_ack(cpu_ack),
        .req_valid(req_valid), .req_level(req_level), .req_id(req_id),
        .imask_wr(imask_wr), .imask_level(imask_level),
        .ack_take(ack_take), .ack_id(ack_id)
    );

    // R4
    offer_above_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_id != '0) |->
            (req_level > $past(cpu_imask)) && (req_level > $past(umask)) && !$past(cpu_bl));

    // R5
    nmi_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_id == '0) |->
            (!$past(cpu_bl) || $past(nmi_pass_bl)) && req_level == NMI_LVL);
endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  ext_irq = '0;
    logic [7:0]  per_irq = '0;
    logic        nmi_pin = 1'b0;
    logic        cpu_bl = 1'b0;
    logic [4:0]  cpu_imask = '0;
    logic        cpu_ack = 1'b0;
    logic        req_valid;
    logic [4:0]  req_level;
    logic [3:0]  req_id;
    logic        imask_wr;
    logic [4:0]  imask_level;

    always #2 clk = ~clk;

    prio_irq_ctrl u_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ext_irq(ext_irq), .per_irq(per_irq), .nmi_pin(nmi_pin),
        .cpu_bl(cpu_bl), .cpu_imask(cpu_imask), .cpu_ack(cpu_ack),
        .req_valid(req_valid), .req_level(req_level), .req_id(req_id),
        .imask_wr(imask_wr), .imask_level(imask_level)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;
    bit    run = 0;
    string cur_tag = "R10";

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // behavioural reference model
    int m_pe[4];
    int m_pp[8];
    int m_umask, m_st, m_lvl, m_id;
    bit m_pass, m_hold, m_nprev, m_npend;
    bit m_latch[4];

    function automatic int exp_rdata(input int a);
        int r = 0;
        if (a == 0) r = int'(m_pass) + 2 * int'(m_hold) + 256 * int'(nmi_pin);
        else if (a == 1) r = m_umask;
        else if (a == 2) begin
            for (int i = 0; i < 4; i++) if (m_latch[i]) r += (1 << i);
        end else if (a == 4) begin
            for (int i = 0; i < 4; i++) r += m_pe[i] << (4 * i);
        end else if (a == 8 || a == 9) begin
            for (int j = 0; j < 4; j++) r += m_pp[(a - 8) * 4 + j] << (8 * j);
        end
        return r;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin m_pe[i] = 0; m_latch[i] = 0; end
            for (int j = 0; j < 8; j++) m_pp[j] = 0;
            m_umask = 0; m_st = 0; m_lvl = 0; m_id = 0;
            m_pass = 0; m_hold = 0; m_nprev = 0; m_npend = 0;
        end else begin
            int best, bid, wl, wi;
            bit wv, acked;
            best = 0; bid = 0; wv = 0; wl = 0; wi = 0;
            for (int i = 0; i < 4; i++)
                if ((ext_irq[i] || (m_hold && m_latch[i])) && m_pe[i] > best) begin
                    best = m_pe[i]; bid = 1 + i;
                end
            for (int j = 0; j < 8; j++)
                if (per_irq[j] && m_pp[j] > best) begin
                    best = m_pp[j]; bid = 5 + j;
                end
            if (m_npend && (!cpu_bl || m_pass)) begin
                wv = 1; wl = 31; wi = 0;
            end else if (best > 0 && !cpu_bl && best > int'(cpu_imask) && best > m_umask) begin
                wv = 1; wl = best; wi = bid;
            end
            acked = (m_st == 1) && cpu_ack;
            for (int i = 0; i < 4; i++) begin
                bit clr;
                clr = (acked && m_id == i + 1) || (reg_we && reg_addr == 2 && reg_wdata[i]);
                m_latch[i] = m_hold ? (ext_irq[i] || (m_latch[i] && !clr)) : 1'b0;
            end
            m_npend = (m_npend && !(acked && m_id == 0)) || (nmi_pin && !m_nprev);
            m_nprev = nmi_pin;
            if (m_st == 0) begin
                if (wv) begin m_st = 1; m_lvl = wl; m_id = wi; end
            end else if (m_st == 1) begin
                if (acked) m_st = 2;
                else if (wv) begin m_lvl = wl; m_id = wi; end
                else m_st = 0;
            end else m_st = 0;
            if (reg_we) begin
                if (reg_addr == 0) begin m_pass = reg_wdata[0]; m_hold = reg_wdata[1]; end
                if (reg_addr == 1) m_umask = int'(reg_wdata[4:0]);
                if (reg_addr == 4)
                    for (int i = 0; i < 4; i++) m_pe[i] = int'(reg_wdata[4*i +: 4]);
                if (reg_addr == 8 || reg_addr == 9)
                    for (int j = 0; j < 4; j++) begin
                        int v;
                        v = int'(reg_wdata[8*j +: 5]);
                        m_pp[(reg_addr - 8) * 4 + j] = (v > 30) ? 30 : v;
                    end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && run) begin
            chk(req_valid == (m_st == 1), cur_tag, "req_valid", req_valid, m_st == 1);
            if (m_st == 1) begin
                chk(req_level == m_lvl, cur_tag, "req_level", req_level, m_lvl);
                chk(req_id == m_id, cur_tag, "req_id", req_id, m_id);
            end
            chk(imask_wr == (m_st == 2), cur_tag, "imask_wr", imask_wr, m_st == 2);
            if (m_st == 2)
                chk(imask_level == m_lvl, cur_tag, "imask_level", imask_level, m_lvl);
            chk(reg_rdata == exp_rdata(int'(reg_addr)), cur_tag, "reg_rdata",
                reg_rdata, exp_rdata(int'(reg_addr)));
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic settle();
        repeat (3) tick();
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic expect_req(input string tag, input bit v, input int lvl, input int id);
        chk(req_valid == v, tag, "offer valid", req_valid, v);
        if (v) begin
            chk(req_level == lvl, tag, "offer level", req_level, lvl);
            chk(req_id == id, tag, "offer id", req_id, id);
        end
    endtask

    task automatic do_ack(input string tag, input int lvl);
        cpu_ack = 1'b1;
        tick();
        cpu_ack = 1'b0;
        chk(imask_wr == 1'b1, tag, "write-back pulse", imask_wr, 1);
        chk(imask_level == lvl, tag, "write-back level", imask_level, lvl);
        chk(req_valid == 1'b0, tag, "valid during accept", req_valid, 0);
        tick();
        chk(imask_wr == 1'b0, tag, "pulse length", imask_wr, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R10 reset values, and R7 capture mode off after reset
        repeat (3) tick();
        chk(req_valid == 0, "R10", "reset req_valid", req_valid, 0);
        chk(imask_wr == 0, "R10", "reset imask_wr", imask_wr, 0);
        chk(reg_rdata == 0, "R7", "reset control word", reg_rdata, 0);
        rst_n = 1'b1;
        run = 1;
        tick();

        // R1 pin priorities: pin0=1 pin1=2 pin2=3 pin3=4
        cur_tag = "R1";
        wr(4, 32'h0000_4321);
        chk(reg_rdata == 32'h0000_4321, "R1", "pin priority readback", reg_rdata, 32'h4321);
        ext_irq = 4'b0000;

        // R2 peripheral priorities: src0=0 src1=5 src2=10 src3=31->30, src4=4
        cur_tag = "R2";
        wr(8, 32'h1F0A_0500);
        chk(reg_rdata == 32'h1E0A_0500, "R2", "peripheral saturate", reg_rdata, 32'h1E0A0500);
        wr(9, 32'h0000_0004);
        per_irq[0] = 1'b1;
        settle();
        expect_req("R2", 0, 0, 0);
        per_irq[0] = 1'b0;

        // R3 highest level wins, update while offered, tie to lower id
        cur_tag = "R3";
        ext_irq[2] = 1'b1; per_irq[1] = 1'b1;
        settle();
        expect_req("R3", 1, 5, 6);
        per_irq[2] = 1'b1;
        settle();
        expect_req("R3", 1, 10, 7);
        ext_irq = '0; per_irq = '0;
        settle();
        ext_irq[3] = 1'b1; per_irq[4] = 1'b1;
        settle();
        expect_req("R3", 1, 4, 4);
        ext_irq = '0; per_irq = '0;
        settle();

        // R4 processor mask, user mask, block bit
        cur_tag = "R4";
        per_irq[1] = 1'b1; cpu_imask = 5'd5;
        settle();
        expect_req("R4", 0, 0, 0);
        cpu_imask = 5'd4;
        settle();
        expect_req("R4", 1, 5, 6);
        wr(1, 32'd5);
        settle();
        expect_req("R4", 0, 0, 0);
        wr(1, 32'd4);
        settle();
        expect_req("R4", 1, 5, 6);
        cpu_bl = 1'b1;
        settle();
        expect_req("R4", 0, 0, 0);
        cpu_bl = 1'b0;
        settle();

        // R9 acknowledge and mask write-back
        cur_tag = "R9";
        expect_req("R9", 1, 5, 6);
        do_ack("R9", 5);
        cpu_imask = 5'd5;
        settle();
        expect_req("R9", 0, 0, 0);
        per_irq = '0; cpu_imask = '0;
        wr(1, 32'd0);

        // R5 / R6 non-maskable request gating and pin readback
        cur_tag = "R5";
        cpu_bl = 1'b1; nmi_pin = 1'b1;
        settle();
        expect_req("R5", 0, 0, 0);
        reg_addr = 4'd0;
        tick();
        chk(reg_rdata == 32'h100, "R6", "pin level high", reg_rdata, 32'h100);
        cpu_imask = 5'd31;
        wr(0, 32'd1);
        settle();
        expect_req("R5", 1, 31, 0);
        do_ack("R5", 31);
        settle();
        expect_req("R5", 0, 0, 0);
        cur_tag = "R6";
        nmi_pin = 1'b0;
        tick();
        chk(reg_rdata == 32'h1, "R6", "pin level low", reg_rdata, 32'h1);
        cpu_bl = 1'b0; cpu_imask = '0;
        wr(0, 32'd0);

        // R7 live versus capture mode
        cur_tag = "R7";
        ext_irq[0] = 1'b1;
        settle();
        expect_req("R7", 1, 1, 1);
        ext_irq[0] = 1'b0;
        settle();
        expect_req("R7", 0, 0, 0);
        wr(0, 32'd2);
        ext_irq[0] = 1'b1;
        tick();
        ext_irq[0] = 1'b0;
        settle();
        expect_req("R7", 1, 1, 1);
        reg_addr = 4'd2;
        tick();
        chk(reg_rdata == 32'h1, "R7", "captured bit", reg_rdata, 1);

        // R8 clear by write-one and by acknowledge
        cur_tag = "R8";
        wr(2, 32'h1);
        settle();
        expect_req("R8", 0, 0, 0);
        chk(reg_rdata == 32'h0, "R8", "cleared by write", reg_rdata, 0);
        ext_irq[0] = 1'b1;
        tick();
        ext_irq[0] = 1'b0;
        settle();
        expect_req("R8", 1, 1, 1);
        do_ack("R8", 1);
        settle();
        expect_req("R8", 0, 0, 0);
        chk(reg_rdata == 32'h0, "R8", "cleared by acknowledge", reg_rdata, 0);

        run = 0;
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule